// File: doc/BRIEF.md
# Flex K-Best Tree Search Detector

This block finds the transmitted symbol vector of a four-antenna spatially multiplexed 64-QAM link once the channel has been triangularised. The complex system is split into real and imaginary parts, so the search runs over eight real tree levels. Each level carries one value from the odd-integer alphabet {-7,...,+7}. The caller supplies an 8x8 upper-triangular real matrix and an eight-entry rotated receive vector. It pulses a start strobe and, a fixed number of cycles later, reads back the detected symbol indices and the metric of the winning path.

The two topmost levels (level 8, then level 7) are enumerated in full, which yields 64 candidate paths. Below them, each path grows by only its single closest child, so no level is ever sorted. One cancellation, slicing and metric datapath is shared in time: it handles one path at one level per clock. A running minimum then picks the winning leaf. The per-level error may be accumulated as a squared distance or as an absolute value, which needs no multiplier.

Top module: `flex_sphere_search`

## Requirements
- R1: While reset is held and after its release, `done` is 0 and `det_idx` and `metric` read 0.
- R2: Levels 8 and 7 take every alphabet index k in 0..7, whose value is 2k-7. Candidate path p uses k = p/8 on level 8 and k = p%8 on level 7, for p = 0..63.
- R3: At level i the cancelled observation is y_i minus the sum over j>i of R(i,j)·s_j, using the symbols of the same path. Entries of R below the diagonal have no effect. The entry in row a, column c (0-based, row a = level a+1) sits at bits [(8a+c)·18 +: 18] of `r_flat`, and y of level a+1 sits at bits [18a +: 18] of `y_flat`.
- R4: On levels 6 to 1 the chosen symbol is the alphabet value nearest to b_i/R(i,i), clipped to ±7. An exact midpoint resolves to the more negative value. R(i,i) must be positive.
- R5: With `norm_l1`=0 each level adds (b_i − R(i,i)·s_i)²; with `norm_l1`=1 it adds |b_i − R(i,i)·s_i|. The mode is sampled with start.
- R6: Both the per-level increment and the running path metric saturate at 2^18−1 and never wrap.
- R7: The reported vector is the path with the lowest final metric. On equal metrics the lowest path index wins.
- R8: `done` is a one-cycle pulse. It is high after the 513th rising edge that follows the edge sampling `start`, i.e. 64·8 cycles of path processing plus one for the final selection.
- R9: Matrix, vector and mode are captured on the accepted start. A start, or any input change, while a search is running has no effect on its result or its timing.
- R10: `det_idx` holds the index k of level a+1 at bits [3a +: 3]. `det_idx` and `metric` keep their values after `done` until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| norm_l1 | input | 1 | 1 selects absolute-error metric, 0 squared error |
| r_flat | input | 1152 | 8x8 real triangular matrix, 18-bit signed entries |
| y_flat | input | 144 | Rotated receive vector, 18-bit signed entries |
| done | output | 1 | One-cycle pulse when the result is ready |
| det_idx | output | 24 | Detected alphabet indices, 3 bits per level |
| metric | output | 18 | Final metric of the detected path |

## Verification
The bench aims at midpoint ties: with a zero receive vector and a unit diagonal, every level sits exactly between −1 and +1. A slicer that rounds the wrong way, or a minimum search that lets a later path win a tie, reports a different vector or index. Huge receive values drive every path into saturation. A wrapping adder would then return a small metric and a wrong winner. Noiseless vectors must come back exactly with metric zero, which exposes errors in the cancellation ordering or in the level-to-bit mapping. A start pulsed mid-run with corrupted inputs must leave the result and the 513-cycle latency untouched.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_state_e;

  // real-axis alphabet value of index idx for an nsym-point axis
  function automatic int sym_val(input int idx, input int nsym);
    return 2 * idx - (nsym - 1);
  endfunction
endpackage

// File: rtl/sd_cancel.sv
module sd_cancel #(
  parameter int NL   = 8,
  parameter int NSYM = 8,
  parameter int DW   = 18,
  parameter int SW   = 3,
  parameter int EW   = 26,
  parameter int LW   = 3
) (
  input  logic [NL*DW-1:0]        r_row,
  input  logic signed [DW-1:0]    y_i,
  input  logic [NL*SW-1:0]        syms,
  input  logic [LW-1:0]           lvl,
  output logic signed [EW-1:0]    b
);
  import sd_pkg::*;

  logic signed [EW-1:0] acc;
  logic signed [DW-1:0] rj;
  logic signed [EW-1:0] term;

  always_comb begin
    acc  = EW'(y_i);
    rj   = '0;
    term = '0;
    for (int j = 0; j < NL; j++) begin
      if (j > int'(lvl)) begin
        rj   = $signed(r_row[j*DW +: DW]);
        term = EW'(rj) * EW'(sym_val(int'(syms[j*SW +: SW]), NSYM));
        acc  = acc - term;
      end
    end
    b = acc;
  end
endmodule

// File: rtl/sd_slicer.sv
module sd_slicer #(
  parameter int NSYM = 8,
  parameter int DW   = 18,
  parameter int SW   = 3,
  parameter int EW   = 26,
  parameter int MW   = 18
) (
  input  logic signed [EW-1:0] b,
  input  logic signed [DW-1:0] rii,
  input  logic                 force_en,
  input  logic [SW-1:0]        force_idx,
  input  logic                 l1_mode,
  output logic [SW-1:0]        idx,
  output logic signed [EW-1:0] err,
  output logic [MW-1:0]        inc
);
  import sd_pkg::*;

  localparam logic [2*EW-1:0] MAXM = {{(2*EW-MW){1'b0}}, {MW{1'b1}}};

  logic [NSYM-2:0] above;
  logic [SW-1:0]   ladder_idx;
  logic [EW-1:0]   mag;
  logic [2*EW-1:0] raw;

  // threshold ladder: midpoints between neighbouring odd values
  for (genvar k = 1; k < NSYM; k++) begin : g_thr
    assign above[k-1] = b > (EW'(rii) * EW'(2*k - NSYM));
  end

  always_comb begin
    ladder_idx = SW'($countones(above));
    idx        = force_en ? force_idx : ladder_idx;
    err        = b - EW'(rii) * EW'(sym_val(int'(idx), NSYM));
    mag        = err[EW-1] ? EW'(-err) : EW'(err);
    raw        = l1_mode ? {{EW{1'b0}}, mag}
                         : {{EW{1'b0}}, mag} * {{EW{1'b0}}, mag};
    inc        = (raw > MAXM) ? {MW{1'b1}} : raw[MW-1:0];
  end
endmodule

// File: rtl/sd_sequencer.sv
module sd_sequencer #(
  parameter int NL    = 8,
  parameter int NPATH = 64,
  parameter int LW    = 3,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          fin,
  output logic          leaf,
  output logic [LW-1:0] lvl,
  output logic [PW-1:0] path,
  output logic          done
);
  import sd_pkg::*;

  seq_state_e st;

  assign accept = start && (st == SQ_IDLE);
  assign busy   = (st == SQ_RUN);
  assign fin    = (st == SQ_FIN);
  assign leaf   = busy && (lvl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      lvl  <= '0;
      path <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st   <= SQ_RUN;
          path <= '0;
          lvl  <= LW'(NL-1);
        end
        SQ_RUN: begin
          if (lvl == '0) begin
            lvl <= LW'(NL-1);
            if (path == PW'(NPATH-1)) st <= SQ_FIN;
            else path <= path + 1'b1;
          end else begin
            lvl <= lvl - 1'b1;
          end
        end
        SQ_FIN: begin
          st   <= SQ_IDLE;
          done <= 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (lvl != '0) |=> busy && (lvl == $past(lvl) - 1'b1) && $stable(path));
endmodule

// File: rtl/flex_sphere_search.sv
module flex_sphere_search #(
  parameter int NL   = 8,
  parameter int NFIX = 2,
  parameter int NSYM = 8,
  parameter int DW   = 18,
  parameter int MW   = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                norm_l1,
  input  logic [NL*NL*DW-1:0] r_flat,
  input  logic [NL*DW-1:0]    y_flat,
  output logic                done,
  output logic [NL*$clog2(NSYM)-1:0] det_idx,
  output logic [MW-1:0]       metric
);
  localparam int SW    = $clog2(NSYM);
  localparam int LW    = $clog2(NL);
  localparam int PW    = NFIX * SW;
  localparam int NPATH = 1 << PW;
  localparam int EW    = DW + SW + 1 + LW + 1;
  localparam int CW    = $clog2(NPATH*NL + 2) + 1;

  logic [NL*NL*DW-1:0] r_lat;
  logic [NL*DW-1:0]    y_lat;
  logic                l1_lat;
  logic [NL*SW-1:0]    cur_sym, best_sym, leaf_syms;
  logic [MW-1:0]       t_cur, best_t, t_base, t_new;
  logic [MW:0]         t_sum;

  logic                accept, busy, fin, leaf;
  logic [LW-1:0]       lvl;
  logic [PW-1:0]       path;

  logic [NL*DW-1:0]    r_row;
  logic signed [DW-1:0] y_i, rii;
  logic signed [EW-1:0] b_val, err;
  logic                fixed_lvl;
  logic [SW-1:0]       force_idx, sl_idx;
  logic [MW-1:0]       inc;
  logic                best_upd;
  int                  fsh;

  sd_sequencer #(.NL(NL), .NPATH(NPATH), .LW(LW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .fin(fin), .leaf(leaf), .lvl(lvl), .path(path), .done(done)
  );

  always_comb begin
    r_row     = r_lat[int'(lvl)*NL*DW +: NL*DW];
    y_i       = $signed(y_lat[int'(lvl)*DW +: DW]);
    rii       = $signed(r_row[int'(lvl)*DW +: DW]);
    fixed_lvl = int'(lvl) >= (NL - NFIX);
    fsh       = fixed_lvl ? (int'(lvl) - (NL - NFIX)) * SW : 0;
    force_idx = path[fsh +: SW];
  end

  sd_cancel #(.NL(NL), .NSYM(NSYM), .DW(DW), .SW(SW), .EW(EW), .LW(LW)) u_cancel (
    .r_row(r_row), .y_i(y_i), .syms(cur_sym), .lvl(lvl), .b(b_val)
  );

  sd_slicer #(.NSYM(NSYM), .DW(DW), .SW(SW), .EW(EW), .MW(MW)) u_slice (
    .b(b_val), .rii(rii), .force_en(fixed_lvl), .force_idx(force_idx),
    .l1_mode(l1_lat), .idx(sl_idx), .err(err), .inc(inc)
  );

  always_comb begin
    t_base    = (lvl == LW'(NL-1)) ? '0 : t_cur;
    t_sum     = {1'b0, t_base} + {1'b0, inc};
    t_new     = t_sum[MW] ? {MW{1'b1}} : t_sum[MW-1:0];
    leaf_syms = cur_sym;
    leaf_syms[int'(lvl)*SW +: SW] = sl_idx;
    best_upd  = leaf && ((path == '0) || (t_new < best_t));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_lat    <= '0;
      y_lat    <= '0;
      l1_lat   <= 1'b0;
      cur_sym  <= '0;
      t_cur    <= '0;
      best_sym <= '0;
      best_t   <= '0;
    end else begin
      if (accept) begin
        r_lat  <= r_flat;
        y_lat  <= y_flat;
        l1_lat <= norm_l1;
      end
      if (busy) begin
        cur_sym[int'(lvl)*SW +: SW] <= sl_idx;
        t_cur <= t_new;
        if (best_upd) begin
          best_sym <= leaf_syms;
          best_t   <= t_new;
        end
      end
    end
  end

  assign det_idx = best_sym;
  assign metric  = best_t;

  // latency counter for the window check
  logic [CW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)           lat_cnt <= '0;
    else if (accept)      lat_cnt <= '0;
    else if (busy || fin) lat_cnt <= lat_cnt + 1'b1;
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == CW'(NPATH*NL + 1)));

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || fin) && start |=> $stable(y_lat) && $stable(r_lat) && $stable(l1_lat));

  // R6
  metric_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (lvl != LW'(NL-1)) |=> t_cur >= $past(t_cur));

  // R4
  slice_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fixed_lvl && (rii > 0) && (sl_idx != '0) && (sl_idx != SW'(NSYM-1))
    |-> (err <= EW'(rii)) && (err >= -EW'(rii)));

  // R7
  best_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leaf && (path != '0) |=> best_t <= $past(best_t));
endmodule

// File: tb/flex_sphere_search_test.sv
`timescale 1ns/1ps
module flex_sphere_search_test;
  localparam longint MAXM = 262143;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic norm_l1 = 1'b0;
  logic [8*8*18-1:0] r_flat = '0;
  logic [8*18-1:0]   y_flat = '0;
  logic done;
  logic [23:0] det_idx;
  logic [17:0] metric;

  int errors = 0;
  int checks = 0;
  int rm [8][8];
  int ym [8];

  always #2.5 clk = ~clk;

  flex_sphere_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .norm_l1(norm_l1),
    .r_flat(r_flat), .y_flat(y_flat), .done(done), .det_idx(det_idx), .metric(metric)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // independent restatement: enumerate two levels, greedy nearest child below
  task automatic model(input bit l1, output logic [23:0] edet, output longint emet);
    longint best = -1;
    edet = '0;
    for (int p = 0; p < 64; p++) begin
      int s [8];
      longint t = 0;
      for (int lv = 7; lv >= 0; lv--) begin
        longint b = ym[lv];
        longint e, inc, bd;
        int k = 0;
        for (int j = lv + 1; j < 8; j++) b -= longint'(rm[lv][j]) * (2*s[j] - 7);
        if (lv == 7) k = p / 8;
        else if (lv == 6) k = p % 8;
        else begin
          bd = -1;
          for (int c = 0; c < 8; c++) begin
            longint d = labs(b - longint'(rm[lv][lv]) * (2*c - 7));
            if (bd < 0 || d < bd) begin bd = d; k = c; end
          end
        end
        s[lv] = k;
        e = b - longint'(rm[lv][lv]) * (2*k - 7);
        inc = l1 ? labs(e) : e * e;
        if (inc > MAXM) inc = MAXM;
        t += inc;
        if (t > MAXM) t = MAXM;
      end
      if (best < 0 || t < best) begin
        best = t;
        for (int lv = 0; lv < 8; lv++) edet[lv*3 +: 3] = 3'(s[lv]);
      end
    end
    emet = best;
  endtask

  task automatic pack();
    for (int a = 0; a < 8; a++) begin
      y_flat[a*18 +: 18] = 18'(ym[a]);
      for (int c = 0; c < 8; c++) r_flat[(a*8+c)*18 +: 18] = 18'(rm[a][c]);
    end
  endtask

  task automatic run(input bit l1, input string tag, input bit poke);
    logic [23:0] edet;
    logic [23:0] held;
    longint emet;
    int cnt = 0;
    model(l1, edet, emet);
    pack();
    @(negedge clk);
    norm_l1 = l1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done && cnt < 2000) begin
      @(posedge clk); #1;
      cnt++;
      if (poke && cnt == 100) begin
        start = 1'b1;
        y_flat = ~y_flat;
        r_flat = ~r_flat;
        norm_l1 = ~l1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(cnt == 513, "R8", {tag, " latency"}, cnt, 513);
    check(det_idx == edet, "R7", {tag, " detected vector"}, det_idx, edet);
    check(metric == emet, "R5", {tag, " metric"}, metric, emet);
    held = det_idx;
    @(posedge clk); #1;
    check(done == 1'b0, "R8", {tag, " done pulse width"}, done, 0);
    repeat (3) @(posedge clk); #1;
    check(det_idx == held, "R10", {tag, " hold after done"}, det_idx, held);
  endtask

  task automatic rand_upper(input int dmin, input int dspan, input int off);
    for (int a = 0; a < 8; a++)
      for (int c = 0; c < 8; c++)
        if (c == a) rm[a][c] = dmin + int'($urandom_range(dspan));
        else rm[a][c] = int'($urandom_range(2*off)) - off;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(det_idx == '0, "R1", "det in reset", det_idx, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(metric == '0, "R1", "metric after reset", metric, 0);

    // R3 noiseless recovery, lower triangle junk
    for (int n = 0; n < 4; n++) begin
      logic [23:0] truth;
      rand_upper(30, 200, 40);
      for (int a = 0; a < 8; a++) truth[a*3 +: 3] = 3'($urandom_range(7));
      for (int a = 0; a < 8; a++) begin
        ym[a] = 0;
        for (int c = a; c < 8; c++) ym[a] += rm[a][c] * (2*int'(truth[c*3 +: 3]) - 7);
      end
      run(n[0], "R3 noiseless", 1'b0);
      check(det_idx == truth, "R3", "noiseless vector", det_idx, truth);
      check(metric == '0, "R3", "noiseless metric", metric, 0);
    end

    // R4 R5 random sweeps under both norms
    for (int n = 0; n < 6; n++) begin
      rand_upper(50, 350, 200);
      for (int a = 0; a < 8; a++) ym[a] = int'($urandom_range(6000)) - 3000;
      run(1'b0, "R5 random squared", 1'b0);
      run(1'b1, "R4 random abs", 1'b0);
    end

    // R7 midpoint ties everywhere
    for (int a = 0; a < 8; a++) begin
      ym[a] = 0;
      for (int c = 0; c < 8; c++) rm[a][c] = (a == c) ? 1 : 0;
    end
    run(1'b1, "R7 tie", 1'b0);
    check(det_idx == 24'o33333333, "R7", "tie lowest index", det_idx, 24'o33333333);
    check(metric == 18'd8, "R7", "tie metric", metric, 8);

    // R6 saturation
    for (int a = 0; a < 8; a++) ym[a] = 100000;
    run(1'b0, "R6 saturate", 1'b0);
    check(metric == 18'h3FFFF, "R6", "saturated metric", metric, MAXM);
    check(det_idx[23:18] == 6'o00, "R2", "first path wins saturated tie", det_idx[23:18], 0);

    // R9 start and input changes mid-run ignored
    rand_upper(40, 300, 150);
    for (int a = 0; a < 8; a++) ym[a] = int'($urandom_range(4000)) - 2000;
    run(1'b0, "R9 restart ignored", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule